// File: doc/BRIEF.md
# Tri-Speed Clock Enable Generator

This block paces a byte-wide media interface that always runs on one fixed 125 MHz clock but must carry data at 1000, 100 or 10 Mb/s. No clock is divided. The block gives out single-cycle enable strobes instead: one on every cycle at full speed, one every tenth cycle at the middle speed, and one every hundredth cycle at the slow speed. Downstream adapters use these strobes to repeat or decimate bytes.

Next to the enable, the block produces a square reference level with a 50 % duty cycle. It also produces two single-cycle strobes that mark the cycles in which that level has just gone high or just gone low. The reference can therefore drive an outgoing interface clock from ordinary flops. A registered flag reports whether one of the two reduced speeds is selected.

When the speed select changes, the block restarts its divider in a fixed way. No strobe period is cut short at any speed, and after every switch the reference starts in a known phase.

Top module: `tspd_clken_gen`

## Requirements
- R1: With `speed_sel` at 2'b10 (full speed), `byte_en`, `ref_rise` and `ref_fall` are high on every cycle once the mode is settled, and `ref_lvl` stays low.
- R2: With `speed_sel` at 2'b01 (100 Mb/s), the strobes repeat every 10 cycles, and `ref_lvl` is high for 5 cycles, then low for 5 cycles.
- R3: With `speed_sel` at 2'b00 (10 Mb/s), the strobes repeat every 100 cycles, and `ref_lvl` is high for 50 cycles, then low for 50 cycles.
- R4: At the reduced speeds, `ref_rise` is high only in the first cycle of each high phase of `ref_lvl`. `ref_fall` and `byte_en` are high together, only in the first cycle of each low phase.
- R5: A new speed is seen at the first clock edge after it is applied. After that edge, all strobes and `ref_lvl` are low for one cycle. At the second edge, a reduced speed starts a high phase with `ref_rise` and a full period. At full speed, strobing simply resumes. No period is ever shortened.
- R6: The code 2'b11 behaves as full speed. Moving between 2'b10 and 2'b11 is not a speed change and causes no gap in the strobes.
- R7: `slow_mode` is high after any clock edge at which `speed_sel` was 2'b00 or 2'b01, and low after any other edge that is not under reset.
- R8: While `rst` is high, all outputs are cleared at each edge. After reset, the divider state stands at full speed: a full-speed select strobes from the first edge, and a reduced-speed select goes through the restart of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed 125 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_sel | input | 2 | 2'b00 = 10 Mb/s, 2'b01 = 100 Mb/s, 2'b10 and 2'b11 = 1000 Mb/s |
| byte_en | output | 1 | Byte enable strobe, coincident with the falling reference edge |
| ref_lvl | output | 1 | Square reference level |
| ref_rise | output | 1 | High in the first cycle of a reference high phase |
| ref_fall | output | 1 | High in the first cycle of a reference low phase |
| slow_mode | output | 1 | High while a reduced speed is selected |

## Verification
Each speed code is held long enough to cover several whole periods, and every output is compared on every cycle against a phase computed from the cycles since the code was applied. This separates a wrong divide ratio from a wrong duty split or a misplaced edge strobe.

Changes of speed are applied from reset, from a settled period, and in the middle of a slow period. These cases show whether the restart produces its one quiet cycle and a full first period, or a clipped one. Toggling between the two full-speed codes, and leaving reset straight into full speed, separate a real mode change from a mere change of code.

// File: rtl/tspd_pkg.sv
package tspd_pkg;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1G   = 2'd2
    } spd_mode_e;

    // Registered output bundle of the edge generator
    typedef struct packed {
        logic en;
        logic rise;
        logic fall;
        logic lvl;
        logic slow;
    } strobe_s;

    // Both upper codes map to full speed
    function automatic spd_mode_e decode_sel(input logic [1:0] sel);
        spd_mode_e m;
        case (sel)
            2'b00:   m = SPD_10;
            2'b01:   m = SPD_100;
            default: m = SPD_1G;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tspd_speed_dec.sv
module tspd_speed_dec
    import tspd_pkg::*;
#(
    parameter int MID_DIV  = 10,
    parameter int SLOW_DIV = 100,
    parameter int CW       = $clog2(SLOW_DIV)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    speed_sel,
    output logic          restart,
    output logic          fast,
    output logic          slow,
    output logic [CW-1:0] period_m1,
    output logic [CW-1:0] half
);

    typedef struct packed {
        spd_mode_e mode;
    } dec_state_s;

    dec_state_s st_d, st_q;
    spd_mode_e  mode_now;

    always_comb begin
        mode_now  = decode_sel(speed_sel);
        st_d      = st_q;
        st_d.mode = mode_now;
        restart   = (mode_now != st_q.mode);
        fast      = (mode_now == SPD_1G);
        slow      = !fast;
        case (mode_now)
            SPD_10: begin
                period_m1 = CW'(SLOW_DIV - 1);
                half      = CW'(SLOW_DIV / 2);
            end
            SPD_100: begin
                period_m1 = CW'(MID_DIV - 1);
                half      = CW'(MID_DIV / 2);
            end
            default: begin
                period_m1 = '0;
                half      = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= SPD_1G;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tspd_phase_ctr.sv
module tspd_phase_ctr #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          fast,
    input  logic [CW-1:0] period_m1,
    output logic [CW-1:0] cnt_nxt
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_state_s;

    ctr_state_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            // park on the last phase so the next edge starts a full period
            st_d.cnt = period_m1;
        end else if (fast) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= period_m1) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
        cnt_nxt = st_d.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tspd_edge_gen.sv
module tspd_edge_gen
    import tspd_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          fast,
    input  logic          slow,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [CW-1:0] half,
    output strobe_s       strobe
);

    strobe_s st_d, st_q;

    always_comb begin
        st_d      = '0;
        st_d.slow = slow;
        if (restart) begin
            // one quiet cycle while the divider realigns
            st_d.en   = 1'b0;
            st_d.rise = 1'b0;
            st_d.fall = 1'b0;
            st_d.lvl  = 1'b0;
        end else if (fast) begin
            st_d.en   = 1'b1;
            st_d.rise = 1'b1;
            st_d.fall = 1'b1;
            st_d.lvl  = 1'b0;
        end else begin
            st_d.lvl  = (cnt_nxt < half);
            st_d.rise = (cnt_nxt == '0);
            st_d.fall = (cnt_nxt == half);
            st_d.en   = (cnt_nxt == half);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q;

endmodule

// File: rtl/tspd_clken_gen.sv
module tspd_clken_gen
    import tspd_pkg::*;
#(
    parameter int MID_DIV  = 10,
    parameter int SLOW_DIV = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] speed_sel,
    output logic       byte_en,
    output logic       ref_lvl,
    output logic       ref_rise,
    output logic       ref_fall,
    output logic       slow_mode
);

    localparam int CW = $clog2(SLOW_DIV);

    logic          restart;
    logic          fast;
    logic          slow;
    logic [CW-1:0] period_m1;
    logic [CW-1:0] half;
    logic [CW-1:0] cnt_nxt;
    strobe_s       strobe;

    tspd_speed_dec #(
        .MID_DIV  (MID_DIV),
        .SLOW_DIV (SLOW_DIV),
        .CW       (CW)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .speed_sel (speed_sel),
        .restart   (restart),
        .fast      (fast),
        .slow      (slow),
        .period_m1 (period_m1),
        .half      (half)
    );

    tspd_phase_ctr #(
        .CW (CW)
    ) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .fast      (fast),
        .period_m1 (period_m1),
        .cnt_nxt   (cnt_nxt)
    );

    tspd_edge_gen #(
        .CW (CW)
    ) u_edge (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .fast    (fast),
        .slow    (slow),
        .cnt_nxt (cnt_nxt),
        .half    (half),
        .strobe  (strobe)
    );

    assign byte_en   = strobe.en;
    assign ref_lvl   = strobe.lvl;
    assign ref_rise  = strobe.rise;
    assign ref_fall  = strobe.fall;
    assign slow_mode = strobe.slow;

endmodule

// File: rtl/tspd_clken_chk.sv
module tspd_clken_chk #(
    parameter int SLOW_DIV = 100
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] speed_sel,
    input logic       byte_en,
    input logic       ref_lvl,
    input logic       ref_rise,
    input logic       ref_fall,
    input logic       slow_mode
);

    localparam int HW = $clog2(SLOW_DIV) + 1;
    localparam int HALF_SLOW = SLOW_DIV / 2;

    // consecutive high cycles seen before the current one
    logic [HW-1:0] hi_run_q;

    always_ff @(posedge clk) begin
        if (rst || !ref_lvl) begin
            hi_run_q <= '0;
        end else if (hi_run_q != {HW{1'b1}}) begin
            hi_run_q <= hi_run_q + HW'(1);
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!byte_en && !ref_rise && !ref_fall && !ref_lvl && !slow_mode)); // R8

    AST_FAST_EVERY: assert property (@(posedge clk) disable iff (rst)
        (speed_sel[1] && $past(speed_sel[1])) |=> byte_en); // R1

    AST_FALL_LOW: assert property (@(posedge clk) disable iff (rst)
        ref_fall |-> !ref_lvl); // R4

    AST_RISE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && slow_mode) |-> ref_lvl); // R4

    AST_LVL_ROSE_MARKED: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_lvl) |-> ref_rise); // R4

    AST_NO_DOUBLE_EDGE: assert property (@(posedge clk) disable iff (rst)
        slow_mode |-> !(ref_rise && ref_fall)); // R5

    AST_SLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (slow_mode == !$past(speed_sel[1]))); // R7

    AST_HIGH_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ref_lvl |-> (hi_run_q < HW'(HALF_SLOW))); // R3

endmodule

bind tspd_clken_gen tspd_clken_chk #(
    .SLOW_DIV (SLOW_DIV)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .speed_sel (speed_sel),
    .byte_en   (byte_en),
    .ref_lvl   (ref_lvl),
    .ref_rise  (ref_rise),
    .ref_fall  (ref_fall),
    .slow_mode (slow_mode)
);

// File: tb/test_tspd_clken_gen.sv
module test_tspd_clken_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] speed_sel = 2'b00;
    logic       byte_en, ref_lvl, ref_rise, ref_fall, slow_mode;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    tspd_clken_gen i_tspd_clken_gen (
        .clk       (clk),
        .rst       (rst),
        .speed_sel (speed_sel),
        .byte_en   (byte_en),
        .ref_lvl   (ref_lvl),
        .ref_rise  (ref_rise),
        .ref_fall  (ref_fall),
        .slow_mode (slow_mode)
    );

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected < 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // bundle order: {en, rise, fall, lvl, slow}
    task automatic compare(input logic [4:0] exp, input string req, input int k);
        logic [4:0] act;
        act = {byte_en, ref_rise, ref_fall, ref_lvl, slow_mode};
        vectors = vectors + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s cycle %0d: actual {en,rise,fall,lvl,slow}=%b expected %b",
                     req, k, act, exp);
        end
    endtask

    // Apply sel at the current negedge, then check ncyc cycles.
    // k counts rising edges since the code was applied.
    task automatic run_mode(input logic [1:0] sel, input int ncyc,
                            input bit restarts, input string req);
        int n;
        int h;
        logic s;
        speed_sel = sel;
        s = !sel[1];
        n = sel[1] ? 1 : (sel[0] ? 10 : 100);
        h = n / 2;
        for (int k = 1; k <= ncyc; k++) begin
            logic [4:0] exp;
            @(negedge clk);
            if (restarts && k == 1) begin
                exp = {4'b0000, s};
            end else if (sel[1]) begin
                exp = 5'b11100;
            end else begin
                int p;
                p = (k - 2) % n;
                exp = {p == h, p == 0, p == h, p < h, 1'b1};
            end
            compare(exp, req, k);
        end
    endtask

    task automatic t_reset_hold;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare(5'b00000, "R8 reset hold", i);
        end
    endtask

    task automatic t_mid_speed;
        rst = 1'b0;
        run_mode(2'b01, 35, 1'b1, "R2/R4/R5/R7 mid speed from reset");
    endtask

    task automatic t_slow_speed;
        run_mode(2'b00, 230, 1'b1, "R3/R4/R7 slow speed");
    endtask

    task automatic t_full_speed;
        run_mode(2'b10, 12, 1'b1, "R1/R5 full speed after slow");
        run_mode(2'b11, 12, 1'b0, "R6 code 11 no gap");
        run_mode(2'b10, 8, 1'b0, "R6 back to 10 no gap");
    endtask

    task automatic t_switch_mid_period;
        run_mode(2'b01, 23, 1'b1, "R5 full to mid");
        run_mode(2'b00, 37, 1'b1, "R5 mid to slow");
        run_mode(2'b01, 25, 1'b1, "R5 slow cut mid period to mid");
    endtask

    task automatic t_reset_mid_run;
        run_mode(2'b00, 20, 1'b1, "R3 slow before reset");
        rst = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            compare(5'b00000, "R8 reset during run", i);
        end
        rst = 1'b0;
        run_mode(2'b10, 6, 1'b0, "R8/R1 full speed right after reset");
        rst = 1'b1;
        @(negedge clk);
        compare(5'b00000, "R8 second reset", 0);
        rst = 1'b0;
        run_mode(2'b01, 15, 1'b1, "R8/R5 mid speed right after reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset_hold();
        t_mid_speed();
        t_slow_speed();
        t_full_speed();
        t_switch_mid_period();
        t_reset_mid_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule